// File: doc/BRIEF.md
# Wrapped-Window Tower Block Summer

This block takes one event's worth of signed tower energies and computes a neighbourhood sum for every tower. The grid has 32 rows and 12 columns. The columns form two independent halves of six. The row index wraps around cyclically, so the first and last rows are neighbours. Windows never reach across the boundary between the halves. At the outer columns of each half, the window loses the column that would lie outside the half.

For each tower the block produces two results. The first is a 12-bit unsigned block sum: negative sums are forced to zero and sums above full scale saturate. The second is a seed flag, raised when the raw, unclamped window sum is strictly greater than a programmable signed threshold.

Towers arrive one row per beat on a valid/ready stream. Once all 32 rows are held, the block leaves its load phase and emits one result row per beat on a second valid/ready stream, rows 0 to 31 in order. While the block is emitting it accepts no new grid: `in_ready` is low for the whole emit phase. The consumer may hold `out_ready` low for any number of cycles. While it does, the offered row index, sums and flags stay unchanged. After row 31 is taken, the block returns to loading.

Top module: `tower_block_summer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. The two are never high in the same cycle, so no grid is accepted while results are being emitted.
- R2: After the 32nd input row is accepted, `out_valid` is high in the next cycle with `out_idx` = 0. Rows are emitted in index order 0..31, one per output handshake. `out_last` is high only with index 31. The cycle after the final handshake shows `in_ready` = 1 and `out_valid` = 0.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_idx`, `out_sum` and `out_seed` hold their values into the next cycle.
- R4: Row neighbours are taken modulo 32: row 0 uses rows 31 and 1, and row 31 uses rows 30 and 0.
- R5: Columns 1-4 and 7-10 sum the full 3x3 window of nine towers (own column and both neighbours, three rows each).
- R6: Columns 0 and 6 (left edge of each half) sum only their own column and the column to the right, over three rows (six towers).
- R7: Columns 5 and 11 (right edge of each half) sum only their own column and the column to the left, over three rows (six towers). No window crosses between columns 5 and 6.
- R8: A seed flag is 1 exactly when the unclamped signed window sum is strictly greater than the threshold. This holds when the sum is negative and its clamped output is 0, and it is 0 when the sum equals the threshold.
- R9: A negative window sum is output as 0.
- R10: A window sum above 4095 is output as 4095.
- R11: The threshold is sampled when row 0 of a grid is accepted. Later changes on `seed_thr` have no effect on that grid's flags.
- R12: Column c of an input or output row occupies bits [12c+11:12c] of `in_row` / `out_sum`, and its flag is bit c of `out_seed`. Tower values are 12-bit two's complement. The threshold is 16-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_thr | input | 16 | Signed seed threshold, sampled with row 0 |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Block is loading and accepts a row |
| in_row | input | 144 | Twelve signed 12-bit towers of one row |
| out_valid | output | 1 | Result row offered |
| out_ready | input | 1 | Consumer takes the result row |
| out_idx | output | 5 | Row index of the offered result |
| out_last | output | 1 | Offered row is the last of the grid |
| out_sum | output | 144 | Twelve clamped 12-bit block sums |
| out_seed | output | 12 | Twelve seed flags |

## Verification
The hardest case to reach is a seed decision that differs from what the clamped output suggests. One form is a negative window whose output reads zero but whose flag must still follow the signed compare. The other is a window sum exactly equal to the threshold. Constant grids of +1 and -1 give fixed interior and edge sums (±9 and ±6). Thresholds set at -7 and 6 then place one column kind exactly on the boundary and split the two kinds apart. A single-tower impulse on row 0 at the right edge of the lower half shows the row wrap, and the absence of leakage into column 6, at the same time. Every grid changes `seed_thr` after its first row, and random grids are read out under random back-pressure.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int TBS_ROWS = 32;
  localparam int TBS_COLS = 12;
  localparam int TBS_HALF = 6;
  localparam int TBS_TW   = 12;
  localparam int TBS_SW   = 16;
  localparam int TBS_OW   = 12;

  typedef enum logic {ST_LOAD = 1'b0, ST_EMIT = 1'b1} tbs_state_e;
endpackage

// File: rtl/tbs_grid_buf.sv
module tbs_grid_buf #(
  parameter int ROWS = 32,
  parameter int RW   = 144,
  localparam int IW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [RW-1:0] wr_row,
  input  logic [IW-1:0] rd_idx,
  output logic [RW-1:0] rd_dn,
  output logic [RW-1:0] rd_mid,
  output logic [RW-1:0] rd_up
);
  localparam logic [IW-1:0] LAST = IW'(ROWS - 1);

  logic [RW-1:0] mem [ROWS];
  logic [IW-1:0] idx_dn, idx_up;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_row;
  end

  // cyclic neighbours
  always_comb begin
    idx_dn = (rd_idx == '0)   ? LAST : rd_idx - 1'b1;
    idx_up = (rd_idx == LAST) ? '0   : rd_idx + 1'b1;
  end

  assign rd_dn  = mem[idx_dn];
  assign rd_mid = mem[rd_idx];
  assign rd_up  = mem[idx_up];
endmodule

// File: rtl/tbs_window_row.sv
module tbs_window_row #(
  parameter int COLS = 12,
  parameter int HALF = 6,
  parameter int TW   = 12,
  parameter int SW   = 16,
  parameter int OW   = 12
) (
  input  logic [COLS*TW-1:0]   row_dn,
  input  logic [COLS*TW-1:0]   row_mid,
  input  logic [COLS*TW-1:0]   row_up,
  input  logic signed [SW-1:0] thr,
  output logic [COLS*OW-1:0]   sum_o,
  output logic [COLS-1:0]      seed_o
);
  localparam logic signed [SW-1:0] SAT = SW'((1 << OW) - 1);

  logic signed [SW-1:0] vsum [COLS];
  logic signed [SW-1:0] win  [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_vert
    logic signed [TW-1:0] t_dn, t_mid, t_up;
    assign t_dn  = signed'(row_dn[c*TW +: TW]);
    assign t_mid = signed'(row_mid[c*TW +: TW]);
    assign t_up  = signed'(row_up[c*TW +: TW]);
    assign vsum[c] = SW'(t_dn) + SW'(t_mid) + SW'(t_up);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_horiz
    localparam int POS = c % HALF;
    if (POS == 0) begin : g_left
      assign win[c] = vsum[c] + vsum[c+1];
    end else if (POS == HALF - 1) begin : g_right
      assign win[c] = vsum[c-1] + vsum[c];
    end else begin : g_mid
      assign win[c] = vsum[c-1] + vsum[c] + vsum[c+1];
    end

    // seed compares the raw signed sum
    assign seed_o[c] = (win[c] > thr);

    always_comb begin
      if (win[c] < 0)        sum_o[c*OW +: OW] = '0;
      else if (win[c] > SAT) sum_o[c*OW +: OW] = {OW{1'b1}};
      else                   sum_o[c*OW +: OW] = win[c][OW-1:0];
    end
  end
endmodule

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
  import tbs_pkg::*;
#(
  parameter int ROWS = 32,
  localparam int IW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic [IW-1:0] cnt,
  output logic          wr_en,
  output logic          thr_load
);
  localparam logic [IW-1:0] LAST = IW'(ROWS - 1);

  tbs_state_e state;
  logic       rd_go;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_EMIT);
  assign out_last  = out_valid && (cnt == LAST);
  assign wr_en     = in_valid && in_ready;
  assign thr_load  = wr_en && (cnt == '0);
  assign rd_go     = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else if (wr_en || rd_go) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        state <= (state == ST_LOAD) ? ST_EMIT : ST_LOAD;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tower_block_summer.sv
module tower_block_summer
  import tbs_pkg::*;
#(
  parameter int ROWS = TBS_ROWS,
  parameter int COLS = TBS_COLS,
  parameter int HALF = TBS_HALF,
  parameter int TW   = TBS_TW,
  parameter int SW   = TBS_SW,
  parameter int OW   = TBS_OW,
  localparam int IW  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SW-1:0]      seed_thr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COLS*TW-1:0] in_row,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [IW-1:0]      out_idx,
  output logic               out_last,
  output logic [COLS*OW-1:0] out_sum,
  output logic [COLS-1:0]    out_seed
);
  logic                 wr_en, thr_load;
  logic [IW-1:0]        cnt;
  logic signed [SW-1:0] thr_q;
  logic [COLS*TW-1:0]   r_dn, r_mid, r_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_q <= '0;
    else if (thr_load) thr_q <= signed'(seed_thr);
  end

  tbs_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .cnt(cnt), .wr_en(wr_en), .thr_load(thr_load)
  );

  tbs_grid_buf #(.ROWS(ROWS), .RW(COLS*TW)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(cnt), .wr_row(in_row),
    .rd_idx(cnt), .rd_dn(r_dn), .rd_mid(r_mid), .rd_up(r_up)
  );

  tbs_window_row #(.COLS(COLS), .HALF(HALF), .TW(TW), .SW(SW), .OW(OW)) u_win (
    .row_dn(r_dn), .row_mid(r_mid), .row_up(r_up), .thr(thr_q),
    .sum_o(out_sum), .seed_o(out_seed)
  );

  assign out_idx = cnt;
endmodule

// File: rtl/tbs_checker.sv
module tbs_checker #(
  parameter int ROWS = 32,
  parameter int COLS = 12,
  parameter int OW   = 12,
  localparam int IW  = $clog2(ROWS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [IW-1:0]      out_idx,
  input logic               out_last,
  input logic [COLS*OW-1:0] out_sum,
  input logic [COLS-1:0]    out_seed
);
  localparam logic [IW-1:0] LAST = IW'(ROWS - 1);

  p_phase_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) &&
      $stable(out_sum) && $stable(out_seed)));

  p_next_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1));

  p_back_to_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  p_last_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (out_idx == LAST)));

  p_first_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == '0));
endmodule

bind tower_block_summer tbs_checker #(.ROWS(ROWS), .COLS(COLS), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_idx(out_idx), .out_last(out_last),
  .out_sum(out_sum), .out_seed(out_seed)
);

// File: tb/sim_tower_block_summer.sv
`timescale 1ns/1ps
module sim_tower_block_summer;
  localparam int ROWS = 32, COLS = 12, HALF = 6, TW = 12, SW = 16, OW = 12;
  localparam int IW = $clog2(ROWS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic [SW-1:0]      seed_thr;
  logic               in_valid, in_ready;
  logic [COLS*TW-1:0] in_row;
  logic               out_valid, out_ready, out_last;
  logic [IW-1:0]      out_idx;
  logic [COLS*OW-1:0] out_sum;
  logic [COLS-1:0]    out_seed;

  tower_block_summer u0 (
    .clk(clk), .rst_n(rst_n), .seed_thr(seed_thr),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_last(out_last), .out_sum(out_sum), .out_seed(out_seed)
  );

  int g [ROWS][COLS];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int win_sum(input int r, input int c);
    int s = 0, pos, lo, hi;
    pos = c % HALF;
    lo = (pos == 0) ? c : c - 1;
    hi = (pos == HALF - 1) ? c : c + 1;
    for (int dr = -1; dr <= 1; dr++)
      for (int cc = lo; cc <= hi; cc++)
        s += g[(r + dr + ROWS) % ROWS][cc];
    return s;
  endfunction

  function automatic string col_tag(input int c);
    if (c % HALF == 0) return "R6";
    if (c % HALF == HALF - 1) return "R7";
    return "R5";
  endfunction

  // pattern: 0 zero,1 +1,2 -1,3 max,4 min,5 impulse,6 random
  task automatic fill(input int pat);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        case (pat)
          0: g[r][c] = 0;
          1: g[r][c] = 1;
          2: g[r][c] = -1;
          3: g[r][c] = 2047;
          4: g[r][c] = -2048;
          5: g[r][c] = (r == 0 && c == 5) ? 100 : 0;
          default: g[r][c] = int'($urandom_range(0, 4095)) - 2048;
        endcase
  endtask

  task automatic run_grid(input int pat, input int thr, input bit bp, input string stag);
    int  exp_idx = 0;
    bit  stalled = 0;
    logic [COLS*OW-1:0] held_sum;
    logic [COLS-1:0]    held_seed;
    logic [IW-1:0]      held_idx;
    fill(pat);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 load ready", int'(in_ready), 1);
      in_valid = 1'b1;
      for (int c = 0; c < COLS; c++) in_row[c*TW +: TW] = TW'(g[r][c]);
      // R11: threshold changes after row 0
      seed_thr = (r == 0) ? SW'(thr) : SW'(~thr);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_idx == '0, "R2 first row latency", int'(out_valid), 1);
    while (exp_idx < ROWS) begin
      if (exp_idx > 0 || stalled) @(negedge clk);
      out_ready = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
      chk(in_ready == 1'b0, "R1 no load while emitting", int'(in_ready), 0);
      if (stalled)
        chk(out_idx == held_idx && out_sum == held_sum && out_seed == held_seed && out_valid,
            "R3 hold under stall", int'(out_idx), int'(held_idx));
      chk(out_valid && out_idx == IW'(exp_idx), "R2 row order", int'(out_idx), exp_idx);
      if (out_ready) begin
        chk(out_last == (exp_idx == ROWS - 1), "R2 last flag", int'(out_last), int'(exp_idx == ROWS - 1));
        for (int c = 0; c < COLS; c++) begin
          int w, e;
          w = win_sum(exp_idx, c);
          e = (w < 0) ? 0 : (w > 4095) ? 4095 : w;
          chk(int'(out_sum[c*OW +: OW]) == e, (stag == "") ? col_tag(c) : stag,
              int'(out_sum[c*OW +: OW]), e);
          chk(out_seed[c] == (w > thr), "R8 R11 R12 seed", int'(out_seed[c]), int'(w > thr));
        end
        exp_idx++;
        stalled = 0;
      end else begin
        stalled   = 1;
        held_idx  = out_idx;
        held_sum  = out_sum;
        held_seed = out_seed;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R2 return to load", int'(in_ready), 1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; seed_thr = '0; in_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", int'(out_valid), 0);
    run_grid(0, 0, 0, "");          // zero grid, equality at 0
    run_grid(1, 6, 0, "");          // edges equal threshold, interior above
    run_grid(2, -7, 0, "R9");       // negative sums clamp, seed from raw sum
    run_grid(3, 0, 1, "R10");       // saturation
    run_grid(4, -32768, 0, "R9");   // most negative sums
    run_grid(5, 50, 1, "R4");       // wrap and half split
    for (int k = 0; k < 4; k++)
      run_grid(6, (k * 700) - 900, k[0], "");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule